// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer

This block is an up-counting timer with a programmable clock divider, a programmable wrap limit and two channels. Each channel can act as an output compare, which raises its flag when the counter reaches the channel's compare value, or as an input capture, which stores the counter on a rising edge of its input pin. Software reaches the block through a small word-addressed register bus. The bus is written in one cycle, and its read data follows the address combinationally.

An event-command register lets software force an update, a per-channel event or a trigger with a single write. The command bits act only in the cycle of the write and always read back as zero. The status flags gather update, trigger, per-channel event and per-channel overcapture conditions. Software clears a flag by writing zero to it. An interrupt line is the OR of the enabled flags.

Register word addresses: 0 control (bit 0 count enable), 1 interrupt enable, 2 status, 3 event command, 4 channel config, 5 divider, 6 wrap limit, 7 counter, 8 channel 0 compare/capture value, 9 channel 1 compare/capture value.

Top module: `cc_timer_core`

## Requirements
- R1: After reset the counter reads 0, the status register reads 0 and `irq` is low.
- R2: While control bit 0 is set, the counter advances by one every divider+1 clocks. The divider is written at address 5.
- R3: On a count step with the counter at or above the wrap limit (address 6), the counter goes to 0 and status bit 0 (update flag) is set.
- R4: Writing 1 to event command bit 0 clears the counter and the divider phase in that cycle and sets the update flag. The divider value is kept, so the next step comes divider+1 clocks later.
- R5: With a channel's preload bit set (config bit 3 for channel 0, bit 11 for channel 1), a compare-value write stays pending and becomes active on the next update event.
- R6: With the preload bit clear, a compare-value write becomes active at once.
- R7: Writing 1 to event command bit 6 sets status bit 6 (trigger flag). `irq` is high while that flag and interrupt-enable bit 6 are both set.
- R8: A channel whose 2-bit select field is 00 (config bits 1:0 for channel 0, 9:8 for channel 1) is in output mode. Writing 1 to its event command bit (bit 1 for channel 0, bit 2 for channel 1) sets its status flag (same bit positions) and leaves its stored value unchanged.
- R9: A channel with a non-zero select field is in input mode. A forced event on it copies the current counter into its value register and sets its status flag.
- R10: A capture that occurs while the channel's flag is already set also sets its overcapture flag (status bit 9 for channel 0, bit 10 for channel 1).
- R11: In input mode, a rising edge on `cap_in` is captured through a two-stage synchronizer. The capture happens on the third clock edge after the pin rises.
- R12: In output mode, the channel flag is set on the count step that brings the counter to the channel's active compare value.
- R13: Writing 0 to a status bit clears it and writing 1 leaves it as it is. Writing 0 to event command bits changes nothing, and the event command register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| irq | output | 1 | OR of enabled status flags |

## Verification
The assertions assume that at most one register write arrives per cycle and that `cap_in` is held long enough for the synchronizer to see a rise. They also assume that the counter is only loaded by software while no step is pending, because a load overrides the step. The stimulus drives every write and every pin change on the falling edge. It stops the counter before it loads the counter or forces captures, so each captured value is known exactly. Hardware edges are held for several cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 4;

    // event command bit positions (decoded by neighbouring logic)
    localparam int EV_UPD   = 0;
    localparam int EV_CH0   = 1;
    localparam int EV_TRG   = 6;
    // status bit positions
    localparam int ST_UPD   = 0;
    localparam int ST_CH0   = 1;
    localparam int ST_TRG   = 6;
    localparam int ST_OVC0  = 9;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_IEN   = 4'd1,
        RA_STAT  = 4'd2,
        RA_EVCMD = 4'd3,
        RA_CHCFG = 4'd4,
        RA_DIV   = 4'd5,
        RA_LIMIT = 4'd6,
        RA_COUNT = 4'd7,
        RA_VAL0  = 4'd8,
        RA_VAL1  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic       preload;
        logic [1:0] sel;
    } ch_cfg_t;

    function automatic logic cfg_is_input(ch_cfg_t c);
        return c.sel != 2'b00;
    endfunction

    function automatic ch_cfg_t cfg_from_byte(logic [7:0] b);
        ch_cfg_t c;
        c.sel     = b[1:0];
        c.preload = b[3];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(ch_cfg_t c);
        return {4'b0000, c.preload, 1'b0, c.sel};
    endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] ratio,
    output logic         step
);
    logic [W-1:0] phase;

    assign step = run && !restart && (phase >= ratio);

    always_ff @(posedge clk) begin
        if (rst)            phase <= '0;
        else if (restart)   phase <= '0;
        else if (run) begin
            if (phase >= ratio) phase <= '0;
            else                phase <= phase + 1'b1;
        end
    end

    // R4: a forced restart leaves the divider phase at zero
    p_phase_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase == '0);

    // R2: the phase holds while counting is stopped
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(phase));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         force_zero,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value,
    output logic [W-1:0] value_next,
    output logic         advancing,
    output logic         wrap
);
    assign advancing = step && !force_zero && !load;
    assign wrap      = advancing && (value >= limit);

    always_comb begin
        if (force_zero)     value_next = '0;
        else if (load)      value_next = load_val;
        else if (wrap)      value_next = '0;
        else if (advancing) value_next = value + 1'b1;
        else                value_next = value;
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= value_next;
    end

    // R3: a step at the limit returns the counter to zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> value == '0);

    // R4: a forced update zeroes the counter
    p_force_zero_r4: assert property (@(posedge clk) disable iff (rst)
        force_zero |=> value == '0);

    // R2: a step below the limit adds exactly one
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (advancing && value < limit) |=> value == $past(value) + 1'b1);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ch_cfg_t      cfg,
    input  logic         pin,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_next,
    input  logic         cnt_adv,
    input  logic         force_evt,
    input  logic         upd_evt,
    input  logic         wr_val,
    input  logic [W-1:0] wdata,
    input  logic         flag_now,
    output logic [W-1:0] val_active,
    output logic         flag_set,
    output logic         ovc_set
);
    logic         s1, s2, s3;
    logic         rise;
    logic         is_in;
    logic         capture;
    logic         match;
    logic [W-1:0] val_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise     = s2 && !s3;
    assign is_in    = cfg_is_input(cfg);
    assign capture  = is_in && (force_evt || rise);
    assign match    = !is_in && cnt_adv && (cnt_next == val_active);
    assign flag_set = capture || match || (!is_in && force_evt);
    assign ovc_set  = capture && flag_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_pend   <= '0;
            val_active <= '0;
        end else begin
            if (wr_val) val_pend <= wdata;
            if (capture)                       val_active <= cnt;
            else if (wr_val && !cfg.preload)   val_active <= wdata;
            else if (upd_evt && cfg.preload)   val_active <= val_pend;
        end
    end

    // R9: a capture stores the counter seen in that cycle
    p_capture_value_r9: assert property (@(posedge clk) disable iff (rst)
        capture |=> val_active == $past(cnt));

    // R8: an output-mode forced event alone never changes the stored value
    p_out_force_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_in && force_evt && !wr_val && !upd_evt) |=> $stable(val_active));

    // R5: with preload on, a write alone does not reach the active value
    p_preload_defer_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.preload && wr_val && !capture && !upd_evt) |=> $stable(val_active));

endmodule

// File: rtl/cc_timer_core.sv
module cc_timer_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NCH-1:0]    cap_in,
    output logic              irq
);
    localparam int ST_CH_TOP = ST_CH0 + NCH - 1;

    logic           run_q;
    logic [6:0]     ien_q;
    logic           upd_f, trg_f;
    logic [NCH-1:0] ch_f, ovc_f;
    ch_cfg_t        cfg_q [NCH];
    logic [W-1:0]   div_q, limit_q;

    logic           wr_ctrl, wr_ien, wr_stat, wr_cmd, wr_cfg, wr_div, wr_lim, wr_cnt;
    logic           f_upd, f_trg;
    logic [NCH-1:0] f_ch, wr_val;
    logic           step, adv, wrap, upd_evt;
    logic [W-1:0]   cnt, cnt_next;
    logic [NCH-1:0] ch_set, ch_ovc;
    logic [W-1:0]   val [NCH];

    assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
    assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
    assign wr_stat = bus_wr && (bus_addr == RA_STAT);
    assign wr_cmd  = bus_wr && (bus_addr == RA_EVCMD);
    assign wr_cfg  = bus_wr && (bus_addr == RA_CHCFG);
    assign wr_div  = bus_wr && (bus_addr == RA_DIV);
    assign wr_lim  = bus_wr && (bus_addr == RA_LIMIT);
    assign wr_cnt  = bus_wr && (bus_addr == RA_COUNT);

    assign f_upd   = wr_cmd && bus_wdata[EV_UPD];
    assign f_trg   = wr_cmd && bus_wdata[EV_TRG];
    assign upd_evt = f_upd || wrap;

    tmr_divider #(.W(W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .restart (f_upd),
        .ratio   (div_q),
        .step    (step)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .force_zero (f_upd),
        .load       (wr_cnt),
        .load_val   (bus_wdata),
        .limit      (limit_q),
        .value      (cnt),
        .value_next (cnt_next),
        .advancing  (adv),
        .wrap       (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign f_ch[i]   = wr_cmd && bus_wdata[EV_CH0 + i];
        assign wr_val[i] = bus_wr && (bus_addr == ADDR_W'(RA_VAL0 + i));

        tmr_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg_q[i]),
            .pin        (cap_in[i]),
            .cnt        (cnt),
            .cnt_next   (cnt_next),
            .cnt_adv    (adv),
            .force_evt  (f_ch[i]),
            .upd_evt    (upd_evt),
            .wr_val     (wr_val[i]),
            .wdata      (bus_wdata),
            .flag_now   (ch_f[i]),
            .val_active (val[i]),
            .flag_set   (ch_set[i]),
            .ovc_set    (ch_ovc[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_f[i]  <= 1'b0;
                ovc_f[i] <= 1'b0;
                cfg_q[i] <= '0;
            end else begin
                ch_f[i]  <= (wr_stat ? (ch_f[i] && bus_wdata[ST_CH0 + i]) : ch_f[i]) || ch_set[i];
                ovc_f[i] <= (wr_stat ? (ovc_f[i] && bus_wdata[ST_OVC0 + i]) : ovc_f[i]) || ch_ovc[i];
                if (wr_cfg) cfg_q[i] <= cfg_from_byte(bus_wdata[8*i +: 8]);
            end
        end

        // R10: a capture onto a set flag raises the overcapture flag
        p_ovc_raise_r10: assert property (@(posedge clk) disable iff (rst)
            ch_ovc[i] |=> ovc_f[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            ien_q   <= '0;
            upd_f   <= 1'b0;
            trg_f   <= 1'b0;
            div_q   <= '0;
            limit_q <= '0;
        end else begin
            if (wr_ctrl) run_q   <= bus_wdata[0];
            if (wr_ien)  ien_q   <= bus_wdata[6:0];
            if (wr_div)  div_q   <= bus_wdata;
            if (wr_lim)  limit_q <= bus_wdata;
            upd_f <= (wr_stat ? (upd_f && bus_wdata[ST_UPD]) : upd_f) || upd_evt;
            trg_f <= (wr_stat ? (trg_f && bus_wdata[ST_TRG]) : trg_f) || f_trg;
        end
    end

    assign irq = (upd_f && ien_q[ST_UPD]) || (trg_f && ien_q[ST_TRG])
               || |(ch_f & ien_q[ST_CH_TOP:ST_CH0]);

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            RA_CTRL:  bus_rdata[0] = run_q;
            RA_IEN:   bus_rdata[6:0] = ien_q;
            RA_STAT: begin
                bus_rdata[ST_UPD]                  = upd_f;
                bus_rdata[ST_TRG]                  = trg_f;
                bus_rdata[ST_CH_TOP:ST_CH0]        = ch_f;
                bus_rdata[ST_OVC0 +: NCH]          = ovc_f;
            end
            RA_CHCFG: begin
                for (int i = 0; i < NCH; i++) bus_rdata[8*i +: 8] = cfg_to_byte(cfg_q[i]);
            end
            RA_DIV:   bus_rdata = div_q;
            RA_LIMIT: bus_rdata = limit_q;
            RA_COUNT: bus_rdata = cnt;
            RA_VAL0:  bus_rdata = val[0];
            RA_VAL1:  bus_rdata = val[1];
            default:  bus_rdata = '0;
        endcase
    end

    // R7: a forced trigger always leaves the trigger flag set
    p_trg_set_r7: assert property (@(posedge clk) disable iff (rst)
        f_trg |=> trg_f);

    // R3/R4: every update event sets the update flag
    p_upd_flag_r3: assert property (@(posedge clk) disable iff (rst)
        upd_evt |=> upd_f);

    // R7: an enabled trigger flag drives the interrupt
    p_irq_trg_r7: assert property (@(posedge clk) disable iff (rst)
        (trg_f && ien_q[ST_TRG]) |-> irq);

    // R13: a status write with the trigger bit clear and no new trigger drops the flag
    p_stat_clear_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !bus_wdata[ST_TRG] && !f_trg) |=> !trg_f);

endmodule

// File: tb/sim_cc_timer_core.sv
module sim_cc_timer_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cc_timer_core u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(7, v); chk("R1 counter", v, 0);
        rd(2, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_count_wrap_match;
        logic [15:0] v;
        wr(4, 16'h0000);
        wr(6, 16'd3);
        wr(5, 16'd1);
        wr(8, 16'd2);
        wr(3, 16'h0001);
        wr(2, 16'h0000);
        wr(1, 16'h0000);
        wr(0, 16'h0001);
        for (int k = 1; k <= 8; k++) begin
            tick(1);
            rd(7, v); chk("R2 count step", v, (k < 8) ? k / 2 : 0);
            rd(2, v);
            chk("R12 compare flag", v[1], k >= 4);
            chk("R3 update flag", v[0], k == 8);
        end
        wr(0, 16'h0000);
    endtask

    task automatic t_forced_update;
        logic [15:0] v;
        wr(6, 16'd100);
        wr(5, 16'd3);
        wr(0, 16'h0001);
        tick(6);
        wr(2, 16'h0000);
        wr(3, 16'h0001);
        rd(7, v); chk("R4 counter cleared", v, 0);
        rd(2, v); chk("R4 update flag", v[0], 1);
        tick(3);
        rd(7, v); chk("R4 ratio kept, no step yet", v, 0);
        tick(1);
        rd(7, v); chk("R4 ratio kept, step", v, 1);
        wr(0, 16'h0000);
    endtask

    task automatic t_preload;
        logic [15:0] v;
        wr(4, 16'h0008);
        wr(8, 16'd7);
        rd(8, v); chk("R5 pending not active", v, 2);
        wr(3, 16'h0001);
        rd(8, v); chk("R5 active after update", v, 7);
        wr(4, 16'h0000);
        wr(8, 16'd9);
        rd(8, v); chk("R6 immediate write", v, 9);
    endtask

    task automatic t_trigger;
        logic [15:0] v;
        wr(1, 16'h0000);
        wr(2, 16'h0000);
        wr(3, 16'h0040);
        rd(2, v); chk("R7 trigger flag", v[6], 1);
        chk("R7 irq masked", irq, 0);
        wr(1, 16'h0040);
        chk("R7 irq enabled", irq, 1);
    endtask

    task automatic t_flag_clear;
        logic [15:0] v, s0;
        rd(2, s0);
        wr(3, 16'h0000);
        rd(2, v); chk("R13 zero command no effect", v, s0);
        rd(3, v); chk("R13 command reads zero", v, 0);
        wr(2, 16'hFFBF);
        rd(2, v); chk("R13 trigger cleared", v[6], 0);
        chk("R13 irq dropped", irq, 0);
        wr(1, 16'h0000);
    endtask

    task automatic t_force_output;
        logic [15:0] v;
        wr(4, 16'h0000);
        wr(9, 16'h0055);
        wr(2, 16'h0000);
        wr(3, 16'h0004);
        rd(2, v); chk("R8 flag set", v, 16'h0004);
        rd(9, v); chk("R8 value kept", v, 16'h0055);
    endtask

    task automatic t_force_input;
        logic [15:0] v;
        wr(4, 16'h0100);
        wr(2, 16'h0000);
        wr(7, 16'h0123);
        wr(3, 16'h0004);
        rd(9, v); chk("R9 captured counter", v, 16'h0123);
        rd(2, v); chk("R9 flag only", v, 16'h0004);
        wr(7, 16'h0124);
        wr(3, 16'h0004);
        rd(9, v); chk("R10 second capture", v, 16'h0124);
        rd(2, v); chk("R10 overcapture", v, 16'h0404);
    endtask

    task automatic t_hw_capture;
        logic [15:0] v;
        wr(4, 16'h0002);
        wr(2, 16'h0000);
        wr(7, 16'h0077);
        cap_in[0] = 1'b1;
        tick(2);
        rd(8, v); chk("R11 not yet captured", v, 9);
        rd(2, v); chk("R11 no flag yet", v[1], 0);
        tick(1);
        rd(8, v); chk("R11 captured", v, 16'h0077);
        rd(2, v); chk("R11 flag", v[1], 1);
        tick(4);
        rd(2, v); chk("R11 single capture", v[9], 0);
        cap_in[0] = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count_wrap_match();
        t_forced_update();
        t_preload();
        t_trigger();
        t_flag_clear();
        t_force_output();
        t_force_input();
        t_hw_capture();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule